// File: doc/BRIEF.md
# Programmable Card Clock Generator

This block produces the bus clock for a memory-card interface. A single 32-bit configuration word is written and read over a plain register port in the system clock domain. From that word the block picks one of four free-running source clocks, divides it in two cascaded stages (a power-of-two prescaler, then a linear divide by M+1), and drives the result out through a clean on/off gate.

Source changes go through a handshaking selector: the outgoing source's enable is dropped while that clock is low, and only then is the incoming source's enable raised, also while low. Divider ratio changes wait for the end of a full output period. Gate changes wait for a low output phase. No shortened high or low phase reaches the card. Two 3-bit phase codes are held in the same word and driven out as static controls for the card interface logic.

Top module: `card_clk_gen`

## Requirements
- R1: After reset the configuration word reads 0x00000000, `card_clk` is low and both phase outputs are 0.
- R2: Only the defined fields are writable (read-back mask 0x8373070F). A write lands on the next `clk` edge. All other bits read as zero.
- R3: Bits 25:24 select the source: code k routes `src_clk[k]` (code 0 is the fixed oscillator, code 1 the PLL).
- R4: Bits 17:16 hold N. The first stage divides the selected source by 2^N (1, 2, 4 or 8).
- R5: Bits 3:0 hold M. The second stage divides by M+1, so the output period is the source period times 2^N*(M+1).
- R6: With total ratio R = 2^N*(M+1) of 2 or more, the output is high for floor(R/2) source periods of each period. With R = 1 the output follows the source itself.
- R7: Bit 31 is the output enable. While it is 0, `card_clk` stays low.
- R8: Bits 22:20 drive `sample_phase` and bits 10:8 drive `drive_phase`. These outputs change only on a register write.
- R9: At most one source is enabled at any time. No output high or low phase is shorter than half a period of the fastest source, across source switches and gate toggles.
- R10: A new N or M takes effect only at an output period boundary. Every output period is wholly at the old or the new ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-port clock |
| rst | input | 1 | Synchronous active-high reset, `clk` domain |
| wr_en | input | 1 | Write strobe for the configuration word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Current configuration word |
| src_clk | input | 4 | Source clocks, index = select code |
| card_clk | output | 1 | Divided, gated card clock |
| sample_phase | output | 3 | Stored sample phase code |
| drive_phase | output | 3 | Stored output phase code |

## Verification
The bench measures the period and high time of the output for source, N and M combinations that include a ratio of 1, an odd ratio and the largest ratio. A wrong prescaler or divider stage would give a scaled period. A wrong duty rule would give a shifted falling edge. An edge detector watches the output for the whole run and counts every phase narrower than the fastest source half-period. Rapid source switches and gate toggles are fed to it, so a selector that overlaps two enables, or a gate applied mid-pulse, shows up as a runt. A ratio change is written part way through a period, and each following period must match either the old or the new ratio exactly, which catches a divider that reloads mid-count.

// File: rtl/ccg_pkg.sv
`timescale 1ns/1ps
package ccg_pkg;
    localparam int NUM_SRC = 4;
    localparam int SEL_W   = $clog2(NUM_SRC);
    localparam int N_W     = 2;
    localparam int M_W     = 4;
    localparam int PH_W    = 3;
    localparam int WORD_W  = 32;
    localparam int PC_W    = (1 << N_W) - 1;
    localparam int RATIO_W = M_W + 1 + PC_W;

    localparam int GATE_BIT = 31;
    localparam int SRC_LSB  = 24;
    localparam int SPH_LSB  = 20;
    localparam int N_LSB    = 16;
    localparam int DPH_LSB  = 8;
    localparam int M_LSB    = 0;

    localparam logic [WORD_W-1:0] CFG_MASK = 32'h8373_070F;

    typedef struct packed {
        logic             gate;
        logic [SEL_W-1:0] src;
        logic [PH_W-1:0]  smp_ph;
        logic [N_W-1:0]   n;
        logic [PH_W-1:0]  drv_ph;
        logic [M_W-1:0]   m;
    } ccg_cfg_t;

    typedef struct packed {
        logic           gate;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } div_set_t;

    function automatic ccg_cfg_t cfg_unpack(logic [WORD_W-1:0] w);
        ccg_cfg_t c;
        c.gate   = w[GATE_BIT];
        c.src    = w[SRC_LSB +: SEL_W];
        c.smp_ph = w[SPH_LSB +: PH_W];
        c.n      = w[N_LSB +: N_W];
        c.drv_ph = w[DPH_LSB +: PH_W];
        c.m      = w[M_LSB +: M_W];
        return c;
    endfunction

    function automatic logic [RATIO_W-1:0] div_ratio(logic [N_W-1:0] n, logic [M_W-1:0] m);
        return (RATIO_W'(m) + RATIO_W'(1)) << n;
    endfunction
endpackage

// File: rtl/ccg_cfg_reg.sv
`timescale 1ns/1ps
module ccg_cfg_reg
    import ccg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output ccg_cfg_t          cfg,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else if (wr_en)
            word_q <= wdata & CFG_MASK;
    end

    assign rdata = word_q;
    assign cfg   = cfg_unpack(word_q);

    AST_WRITE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rdata == ($past(wdata) & CFG_MASK)));  // R2
endmodule

// File: rtl/ccg_src_mux.sv
`timescale 1ns/1ps
module ccg_src_mux
    import ccg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic [SEL_W-1:0]   sel,
    output logic               mux_clk
);
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] gated;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam logic EN_RST = (i == 0);
        logic [1:0] rst_sync;
        logic       rst_i;
        logic       others_off;
        logic       stage_q;
        logic       en_q;

        always_ff @(posedge src_clk[i])
            rst_sync <= {rst_sync[0], rst};
        assign rst_i = rst_sync[1];

        assign others_off = ~|(en & ~(NUM_SRC'(1) << i));

        always_ff @(posedge src_clk[i]) begin
            if (rst_i)
                stage_q <= EN_RST;
            else
                stage_q <= (sel == SEL_W'(i)) && others_off;
        end

        always_ff @(negedge src_clk[i]) begin
            if (rst_i)
                en_q <= EN_RST;
            else
                en_q <= stage_q;
        end

        assign en[i]    = en_q;
        assign gated[i] = src_clk[i] & en_q;
    end

    assign mux_clk = |gated;

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(en));  // R9
endmodule

// File: rtl/ccg_divider.sv
`timescale 1ns/1ps
module ccg_divider
    import ccg_pkg::*;
(
    input  logic           mux_clk,
    input  logic           rst,
    input  logic [N_W-1:0] n_in,
    input  logic [M_W-1:0] m_in,
    input  logic           gate_in,
    output logic           card_clk
);
    logic [1:0]         rst_sync;
    logic               rst_m;
    div_set_t           sy1, sy2;
    logic [PC_W-1:0]    pc, pc_nx, pre_top;
    logic [M_W-1:0]     mc, mc_nx;
    logic [N_W-1:0]     cur_n;
    logic [M_W-1:0]     cur_m;
    logic               out_q, gate_q;
    logic               pre_last, eop, bypass, div_o;
    logic [RATIO_W-1:0] idx_nx, half_cur, half_new;

    always_ff @(posedge mux_clk) begin
        rst_sync <= {rst_sync[0], rst};
        sy1      <= '{gate: gate_in, n: n_in, m: m_in};
        sy2      <= sy1;
    end
    assign rst_m = rst_sync[1];

    always_comb begin
        pre_top  = ~({PC_W{1'b1}} << cur_n);
        pre_last = (pc == pre_top);
        eop      = pre_last && (mc == cur_m);
        pc_nx    = pre_last ? '0 : pc + PC_W'(1);
        mc_nx    = pre_last ? mc + M_W'(1) : mc;
        idx_nx   = (RATIO_W'(mc_nx) << cur_n) | RATIO_W'(pc_nx);
        half_cur = div_ratio(cur_n, cur_m) >> 1;
        half_new = div_ratio(sy2.n, sy2.m) >> 1;
        bypass   = (cur_n == '0) && (cur_m == '0);
    end

    always_ff @(posedge mux_clk) begin
        if (rst_m) begin
            pc    <= '0;
            mc    <= '0;
            cur_n <= '0;
            cur_m <= '0;
            out_q <= 1'b0;
        end else if (eop) begin
            pc    <= '0;
            mc    <= '0;
            cur_n <= sy2.n;
            cur_m <= sy2.m;
            out_q <= (half_new != '0);
        end else begin
            pc    <= pc_nx;
            mc    <= mc_nx;
            out_q <= (idx_nx < half_cur);
        end
    end

    assign div_o = bypass ? mux_clk : out_q;

    always_ff @(negedge mux_clk) begin
        if (rst_m)
            gate_q <= 1'b0;
        else if (bypass || !out_q)
            gate_q <= sy2.gate;
    end

    assign card_clk = div_o & gate_q;

    AST_CNT_RANGE: assert property (@(posedge mux_clk) disable iff (rst_m)
        (mc <= cur_m) && (pc <= pre_top));  // R5
    AST_RELOAD_BOUNDARY: assert property (@(posedge mux_clk) disable iff (rst_m)
        ((cur_n != $past(cur_n)) || (cur_m != $past(cur_m))) |-> (pc == '0 && mc == '0));  // R10
endmodule

// File: rtl/card_clk_gen.sv
`timescale 1ns/1ps
module card_clk_gen
    import ccg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  rdata,
    input  logic [NUM_SRC-1:0] src_clk,
    output logic               card_clk,
    output logic [PH_W-1:0]    sample_phase,
    output logic [PH_W-1:0]    drive_phase
);
    ccg_cfg_t cfg;
    logic     mux_clk;

    ccg_cfg_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .wdata (wdata),
        .cfg   (cfg),
        .rdata (rdata)
    );

    ccg_src_mux u_mux (
        .clk     (clk),
        .rst     (rst),
        .src_clk (src_clk),
        .sel     (cfg.src),
        .mux_clk (mux_clk)
    );

    ccg_divider u_div (
        .mux_clk  (mux_clk),
        .rst      (rst),
        .n_in     (cfg.n),
        .m_in     (cfg.m),
        .gate_in  (cfg.gate),
        .card_clk (card_clk)
    );

    assign sample_phase = cfg.smp_ph;
    assign drive_phase  = cfg.drv_ph;

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(sample_phase) && $stable(drive_phase)));  // R8
endmodule

// File: tb/sim_card_clk_gen.sv
`timescale 1ns/1ps
module sim_card_clk_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
    logic        card_clk;
    logic [2:0]  sample_phase, drive_phase;

    real HALF [4] = '{20.833, 4.0, 7.0, 15.0};
    localparam real MIN_PHASE = 4.0;

    int checks = 0;
    int fails  = 0;
    int runts  = 0;
    bit done   = 0;

    typedef struct { real per; real hi; string tag; } exp_t;
    exp_t q[$];

    card_clk_gen u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .src_clk({s3, s2, s1, s0}), .card_clk(card_clk),
        .sample_phase(sample_phase), .drive_phase(drive_phase)
    );

    always #5 clk = ~clk;
    initial forever #(HALF[0]) s0 = ~s0;
    initial forever #(HALF[1]) s1 = ~s1;
    initial forever #(HALF[2]) s2 = ~s2;
    initial forever #(HALF[3]) s3 = ~s3;

    task automatic chk_v(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_r(string req, string what, real act, real exp);
        checks++;
        if (act - exp > 0.05 || exp - act > 0.05) begin
            fails++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] word(int src, int n, int m, bit g);
        return (32'(g) << 31) | (32'(src) << 24) | (32'(n) << 16) | 32'(m);
    endfunction

    // Driver: program a setting, let it settle, push the expected period.
    task automatic run_cfg(int src, int n, int m, string tag);
        int  r;
        real p, hi;
        wr(word(src, n, m, 1'b1));
        r  = (m + 1) << n;
        p  = 2.0 * HALF[src] * r;
        hi = (r == 1) ? HALF[src] : 2.0 * HALF[src] * (r / 2);
        #(4.0 * p + 600.0);
        q.push_back('{per: p, hi: hi, tag: tag});
        while (q.size() != 0) @(negedge clk);
    endtask

    // Monitor: measure one output period per queued expectation.
    initial begin
        real t0, t1, t2;
        exp_t e;
        forever begin
            while (q.size() == 0) @(negedge clk);
            @(posedge card_clk) t0 = $realtime;
            @(negedge card_clk) t1 = $realtime;
            @(posedge card_clk) t2 = $realtime;
            e = q[0];
            chk_r(e.tag, "period", t2 - t0, e.per);
            chk_r(e.tag, "high time", t1 - t0, e.hi);
            void'(q.pop_front());
        end
    end

    // Runt detector over the whole run (R9).
    initial begin
        real last = 0.0;
        bit  armed = 0;
        forever begin
            @(card_clk);
            if (armed && ($realtime - last) < MIN_PHASE - 0.05) begin
                runts++;
                $display("runt phase of %0.3f ns at %0.3f", $realtime - last, $realtime);
            end
            last = $realtime;
            if (!rst) armed = 1;
        end
    end

    task automatic low_window(string req, string what);
        int hi = 0;
        repeat (300) begin
            @(negedge clk);
            if (card_clk) hi++;
        end
        chk_v(req, what, 32'(hi), 32'd0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        real a, b, w;
        repeat (40) @(negedge clk);
        // R1: reset state
        chk_v("R1", "rdata after reset", rdata, 32'h0);
        chk_v("R1", "card_clk after reset", 32'(card_clk), 32'h0);
        chk_v("R1", "phases after reset", {26'h0, sample_phase, drive_phase}, 32'h0);
        rst = 1'b0;
        low_window("R1", "card_clk low with gate clear");

        // R2: writable mask
        wr(32'hFFFF_FFFF);
        chk_v("R2", "read-back mask", rdata, 32'h8373_070F);
        wr(32'h0000_0000);
        chk_v("R2", "cleared word", rdata, 32'h0);

        // R8 and R7: phases stored, output held low while gate clear
        wr(32'h0050_0300);
        chk_v("R8", "sample phase", 32'(sample_phase), 32'd5);
        chk_v("R8", "drive phase", 32'(drive_phase), 32'd3);
        low_window("R7", "gate clear holds output low");
        chk_v("R8", "phases unchanged without write", {26'h0, sample_phase, drive_phase}, {26'h0, 3'd5, 3'd3});

        // R3..R6: periods and high times
        run_cfg(0, 0, 0, "R6 R3 ratio 1 oscillator");
        run_cfg(1, 1, 4, "R4 R5 R3 PLL ratio 10");
        run_cfg(2, 3, 15, "R4 R5 R3 src2 ratio 128");
        run_cfg(3, 2, 2, "R5 R3 src3 ratio 12");
        run_cfg(1, 0, 2, "R6 odd ratio 3");
        run_cfg(0, 1, 0, "R4 R6 ratio 2 oscillator");
        run_cfg(2, 0, 15, "R5 src2 ratio 16");

        // R7: gate off while running, then back on
        wr(word(2, 0, 15, 1'b0));
        #2000;
        low_window("R7", "gate cleared while running");
        run_cfg(2, 0, 15, "R7 gate set again");

        // R10: ratio change part way through a period
        run_cfg(3, 2, 2, "R10 old ratio 12");
        @(posedge card_clk);
        #100;
        wr(word(3, 0, 3, 1'b1));
        for (int k = 0; k < 6; k++) begin
            @(posedge card_clk) a = $realtime;
            @(posedge card_clk) b = $realtime;
            w = b - a;
            checks++;
            if (!((w > 359.95 && w < 360.05) || (w > 119.95 && w < 120.05))) begin
                fails++;
                $display("FAIL R10 mixed period: actual %0.3f expected 360.000 or 120.000", w);
            end
        end
        chk_r("R10", "settled new ratio", w, 120.0);

        // R9: source switches and gate toggles at odd moments
        for (int k = 0; k < 8; k++) begin
            wr(word(k % 4, k % 2, k % 3, 1'b1));
            #(137 + 29 * k);
            wr(word(k % 4, k % 2, k % 3, k[0]));
            #(91 + 17 * k);
        end
        wr(word(1, 0, 0, 1'b1));
        #1500;
        wr(word(0, 0, 0, 1'b1));
        #1500;
        chk_v("R9", "runt phases seen", 32'(runts), 32'd0);
        run_cfg(0, 0, 0, "R3 R9 oscillator after switching");

        done = 1;
        finish_run();
    end
endmodule